// File: doc/BRIEF.md
# Vector Doubleword Multiply-Sum Unit

This unit performs an unsigned multiply-sum on 128-bit vectors. Each vector holds two 64-bit unsigned lanes. The unit multiplies the upper-lane pair of the two multiplicand vectors and the lower-lane pair of the same vectors, each as a full-width 128-bit product. It can double either product on its own control bit. It then adds both products and a 128-bit addend vector. The result wraps modulo 2^128.

One shared 64x64 multiplier runs twice per operation, so the unit takes three cycles per operation. A caller presents its operands with `valid_i` while `ready_o` is high. A one-cycle `done_o` pulse marks completion. `result_o` keeps its value until the next successful operation. A lane-size code other than doubleword is rejected: the unit raises the exception flag together with `done_o` and leaves `result_o` unchanged.

Top module: `vmsl_unit`

## Requirements
- R1: `esize_i` must be 4'h3. Any other code gives `done_o` and `exc_o` high together, one cycle after acceptance, and `result_o` keeps its previous value.
- R2: Lane 0 occupies bits [127:64] of every vector and lane 1 occupies bits [63:0]. The high half of the 128-bit result appears in `result_o[127:64]`.
- R3: The lane-0 values of `src_a_i` and `src_b_i` are multiplied as unsigned 64x64 numbers into a 128-bit product. The lane-1 values are multiplied the same way.
- R4: When `ctrl_i[3]` is 1, the lane-0 product is shifted left by one before the sum, and its bit 127 is discarded.
- R5: When `ctrl_i[2]` is 1, the lane-1 product is shifted left by one in the same way.
- R6: `result_o` equals lane-0 product + lane-1 product + `addend_i`, all modulo 2^128.
- R7: `ctrl_i[1]` and `ctrl_i[0]` have no effect on the result.
- R8: An operation is accepted on a rising edge with `valid_i` and `ready_o` both high. `ready_o` is low while the unit is busy. For a valid size code, `done_o` is high for exactly one cycle, starting three edges after acceptance. `result_o` changes only in a cycle where `done_o` is high.
- R9: While `rst_ni` is low, `done_o`, `exc_o` and `result_o` are 0 and `ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation request |
| ready_o | output | 1 | Unit idle and able to accept a request |
| esize_i | input | 4 | Lane-size code; only 3 is legal |
| ctrl_i | input | 4 | Bit 3 doubles the lane-0 product, bit 2 doubles the lane-1 product |
| src_a_i | input | 128 | First multiplicand vector |
| src_b_i | input | 128 | Second multiplicand vector |
| addend_i | input | 128 | 128-bit addend |
| result_o | output | 128 | Sum result |
| done_o | output | 1 | One-cycle completion strobe |
| exc_o | output | 1 | Specification exception, valid while `done_o` is high |

## Verification
A wrong phase sequence or a lane mix-up in the operand select shows up in the first result after the request. Examples are multiplying lane 0 twice, or applying a doubling bit to the wrong lane. Small asymmetric operands make each lane's contribution a distinct number, so the first mismatch points to the faulty lane.

A corrupted accumulator, or a dropped carry between the 64-bit halves, first shows up on the all-ones vectors. Those vectors force carries across every bit position and a wrap at bit 127. A wrong handshake state shows up at once as a wrong `ready_o` level or a `done_o` pulse in the wrong cycle. The bench counts cycles from acceptance to `done_o` on every operation.

// File: rtl/vmsl_pkg.sv
package vmsl_pkg;
  localparam int unsigned ELEM_W   = 64;
  localparam int unsigned VEC_W    = 2 * ELEM_W;
  localparam logic [3:0]  ESIZE_DW = 4'h3;
  localparam int unsigned DBL_EVEN = 3;
  localparam int unsigned DBL_ODD  = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVEN = 2'd1,
    ST_ODD  = 2'd2
  } vmsl_state_e;
endpackage

// File: rtl/vmsl_mul.sv
module vmsl_mul #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  assign prod_o = (2*W)'(a_i) * (2*W)'(b_i);

  always_comb begin
    if (a_i == '0 || b_i == '0)
      a_r3_zero_product: assert (prod_o == '0);
  end
endmodule

// File: rtl/vmsl_dbl_add.sv
module vmsl_dbl_add #(
  parameter int unsigned W = 128
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] prod_i,
  input  logic         dbl_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] term;

  assign term  = dbl_i ? {prod_i[W-2:0], 1'b0} : prod_i;
  assign sum_o = acc_i + term;   // wraps modulo 2^W
endmodule

// File: rtl/vmsl_ctrl.sv
module vmsl_ctrl
  import vmsl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [3:0] esize_i,
  output logic       ready_o,
  output logic       load_o,
  output logic       even_o,
  output logic       odd_o,
  output logic       done_o,
  output logic       exc_o
);
  vmsl_state_e state_q, state_d;
  logic        accept, bad_size;

  assign ready_o  = (state_q == ST_IDLE);
  assign accept   = valid_i && ready_o;
  assign bad_size = (esize_i != ESIZE_DW);
  assign load_o   = accept && !bad_size;
  assign even_o   = (state_q == ST_EVEN);
  assign odd_o    = (state_q == ST_ODD);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load_o) state_d = ST_EVEN;
      ST_EVEN: state_d = ST_ODD;
      ST_ODD:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
      exc_o   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= odd_o || (accept && bad_size);
      exc_o   <= accept && bad_size;
    end
  end

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !ready_o);
  a_r1_exc_implies_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> done_o);
  a_r1_bad_size_no_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && bad_size) |=> (ready_o && exc_o));
endmodule

// File: rtl/vmsl_unit.sv
module vmsl_unit
  import vmsl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [3:0]       esize_i,
  input  logic [3:0]       ctrl_i,
  input  logic [VEC_W-1:0] src_a_i,
  input  logic [VEC_W-1:0] src_b_i,
  input  logic [VEC_W-1:0] addend_i,
  output logic [VEC_W-1:0] result_o,
  output logic             done_o,
  output logic             exc_o
);
  logic             load, even, odd;
  logic [VEC_W-1:0] a_q, b_q, acc_q;
  logic             dbl_even_q, dbl_odd_q;
  logic [ELEM_W-1:0] mul_a, mul_b;
  logic [VEC_W-1:0] prod, sum;
  logic             dbl_sel;

  vmsl_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .esize_i (esize_i),
    .ready_o (ready_o),
    .load_o  (load),
    .even_o  (even),
    .odd_o   (odd),
    .done_o  (done_o),
    .exc_o   (exc_o)
  );

  // lane 0 sits in the upper half
  assign mul_a   = even ? a_q[VEC_W-1:ELEM_W] : a_q[ELEM_W-1:0];
  assign mul_b   = even ? b_q[VEC_W-1:ELEM_W] : b_q[ELEM_W-1:0];
  assign dbl_sel = even ? dbl_even_q : dbl_odd_q;

  vmsl_mul #(.W(ELEM_W)) u_mul (
    .a_i    (mul_a),
    .b_i    (mul_b),
    .prod_o (prod)
  );

  vmsl_dbl_add #(.W(VEC_W)) u_add (
    .acc_i  (acc_q),
    .prod_i (prod),
    .dbl_i  (dbl_sel),
    .sum_o  (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q        <= '0;
      b_q        <= '0;
      acc_q      <= '0;
      dbl_even_q <= 1'b0;
      dbl_odd_q  <= 1'b0;
      result_o   <= '0;
    end else begin
      if (load) begin
        a_q        <= src_a_i;
        b_q        <= src_b_i;
        acc_q      <= addend_i;
        dbl_even_q <= ctrl_i[DBL_EVEN];
        dbl_odd_q  <= ctrl_i[DBL_ODD];
      end else if (even) begin
        acc_q <= sum;
      end
      if (odd) result_o <= sum;
    end
  end

  a_r8_result_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));
  a_r1_exc_keeps_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |-> $stable(result_o));
  a_r8_phase_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    even |=> odd);
endmodule

// File: tb/sim_vmsl_unit.sv
module sim_vmsl_unit;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 128;
  localparam int N_TBL = 10;
  localparam int ENT_W = 4*VW + 8;

  // {a, b, addend, esize, ctrl, expected}
  localparam logic [ENT_W-1:0] TBL [N_TBL] = '{
    {128'h2_0000000000000003, 128'h5_0000000000000007, 128'h1, 4'h3, 4'h0, 128'd32},
    {128'h2_0000000000000003, 128'h5_0000000000000007, 128'h1, 4'h3, 4'h8, 128'd42},
    {128'h2_0000000000000003, 128'h5_0000000000000007, 128'h1, 4'h3, 4'h4, 128'd53},
    {128'h2_0000000000000003, 128'h5_0000000000000007, 128'h1, 4'h3, 4'hC, 128'd63},
    {128'h2_0000000000000003, 128'h5_0000000000000007, 128'h1, 4'h3, 4'h3, 128'd32},
    {128'h1, 128'h100000000, 128'h0, 4'h3, 4'h0, 128'h0000000000000000_0000000100000000},
    {128'h8000000000000000_0000000000000000, 128'h4_0000000000000000, 128'h0, 4'h3, 4'h8,
     128'h0000000000000004_0000000000000000},
    {{128{1'b1}}, {128{1'b1}}, 128'h0, 4'h3, 4'h0, 128'hFFFFFFFFFFFFFFFC_0000000000000002},
    {{128{1'b1}}, {128{1'b1}}, {128{1'b1}}, 4'h3, 4'h0, 128'hFFFFFFFFFFFFFFFC_0000000000000001},
    {128'hFFFFFFFFFFFFFFFF_0000000000000000, 128'hFFFFFFFFFFFFFFFF_0000000000000000, 128'h0, 4'h3, 4'h8,
     128'hFFFFFFFFFFFFFFFC_0000000000000002}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic          ready_o;
  logic [3:0]    esize_i = 4'h3;
  logic [3:0]    ctrl_i = 4'h0;
  logic [VW-1:0] src_a_i = '0, src_b_i = '0, addend_i = '0;
  logic [VW-1:0] result_o;
  logic          done_o, exc_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vmsl_unit u0 (.*);

  function automatic logic [VW-1:0] ref_vmsl(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                             input logic [VW-1:0] c, input logic [3:0] ctl);
    logic [VW-1:0] p0, p1;
    p0 = {64'b0, a[127:64]} * {64'b0, b[127:64]};
    p1 = {64'b0, a[63:0]} * {64'b0, b[63:0]};
    if (ctl[3]) p0 = p0 << 1;
    if (ctl[2]) p1 = p1 << 1;
    return p0 + p1 + c;
  endfunction

  task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue one op; returns edges from accept to done
  task automatic run_op(input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [VW-1:0] c,
                        input logic [3:0] es, input logic [3:0] ctl, output int lat);
    int guard;
    guard = 0;
    while (!ready_o && guard < 20) begin @(negedge clk_i); guard++; end
    src_a_i = a; src_b_i = b; addend_i = c; esize_i = es; ctrl_i = ctl; valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 20) begin
      chk("R8 busy", VW'(ready_o), VW'(es != 4'h3 ? 1 : (lat >= 3 ? 1 : 0)));
      @(negedge clk_i); lat++;
    end
  endtask

  initial begin
    logic [VW-1:0] prev, exp, ra, rb, rc;
    logic [3:0] rctl;
    int lat;
    #(3*CLK_PERIOD + 2);
    chk("R9 done in reset", VW'(done_o), 0);
    chk("R9 exc in reset", VW'(exc_o), 0);
    chk("R9 result in reset", result_o, 0);
    chk("R9 ready in reset", VW'(ready_o), 1);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < N_TBL; i++) begin
      run_op(TBL[i][ENT_W-1 -: VW], TBL[i][ENT_W-1-VW -: VW], TBL[i][ENT_W-1-2*VW -: VW],
             TBL[i][VW+7 -: 4], TBL[i][VW+3 -: 4], lat);
      chk("R6 R3 R4 R5 R7 R2 table result", result_o, TBL[i][VW-1:0]);
      chk("R8 latency", VW'(lat), 3);
      chk("R1 no exc", VW'(exc_o), 0);
      @(negedge clk_i);
      chk("R8 done one cycle", VW'(done_o), 0);
    end

    for (int i = 0; i < 40; i++) begin
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      rc = {$urandom, $urandom, $urandom, $urandom};
      rctl = 4'($urandom);
      exp = ref_vmsl(ra, rb, rc, rctl);
      run_op(ra, rb, rc, 4'h3, rctl, lat);
      chk("R6 random result", result_o, exp);
      @(negedge clk_i);
      chk("R8 result held", result_o, exp);
    end

    // illegal sizes: flagged, result untouched
    foreach (TBL[k]) begin : bad_sizes
      logic [3:0] es;
      es = (k == 0) ? 4'h0 : (k == 1) ? 4'h1 : (k == 2) ? 4'h2 : (k == 3) ? 4'h4 : 4'hF;
      if (k < 5) begin
        prev = result_o;
        run_op({128{1'b1}}, {128{1'b1}}, 128'h5, es, 4'hC, lat);
        chk("R1 exc raised", VW'(exc_o), 1);
        chk("R1 exc latency", VW'(lat), 1);
        chk("R1 result untouched", result_o, prev);
        @(negedge clk_i);
        chk("R1 exc cleared", VW'(exc_o), 0);
      end
    end

    // reset mid-operation
    src_a_i = 128'h7_0000000000000009; src_b_i = 128'h3_0000000000000002;
    addend_i = 128'h0; esize_i = 4'h3; ctrl_i = 4'h0; valid_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i); valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk("R9 result cleared", result_o, 0);
    chk("R9 ready after reset", VW'(ready_o), 1);
    @(negedge clk_i); @(negedge clk_i);
    chk("R9 done held low", VW'(done_o), 0);
    rst_ni = 1'b1;
    run_op(128'h7_0000000000000009, 128'h3_0000000000000002, 128'h0, 4'h3, 4'h0, lat);
    chk("R6 after reset", result_o, 128'd39);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule